// File: doc/BRIEF.md
# Full-Duplex Scanner Link Transceiver

This block drives a synchronous serial link to a two-axis scanner head over one outbound line and one inbound line. It divides the system clock down to a continuous, square bit clock and frames every 32 bit clocks with an active-low sync strobe. On each frame it sends one 32-bit command word that joins the X and Y axis positions. During the same frame it collects a 32-bit reply word from the head on the return line. The reply is delivered to the host together with a single-cycle valid pulse.

The host writes a new axis pair whenever it likes. The block picks up the most recent pair at the next frame boundary, and it keeps resending the last pair until a new one arrives. Outbound bits change together with the rising edge of the bit clock. The return line is sampled at the falling edge, in the middle of each bit.

Top module: `scan_duplex_link`

## Requirements
- R1: While reset is held, and for the two system clocks after it is released, sclk is 0, sync_n is 1, sdo is 0, rx_valid is 0 and rx_data is 0.
- R2: sclk is free-running. Each level lasts exactly HALF_DIV system clocks, and the first rising edge comes HALF_DIV system clocks into operation.
- R3: A frame spans 32 bit clocks. sync_n goes to 0 on the rising sclk edge that starts bit 0 and returns to 1 on the rising edge that starts bit 31. sync_n changes only at rising sclk edges.
- R4: The outbound word is {tx_x, tx_y}, so tx_x sits in bits 31:16 and tx_y in bits 15:0. It goes out on sdo most significant bit first, and sdo changes only at rising sclk edges.
- R5: A pulse on tx_wr stores {tx_x, tx_y}, and the stored pair is copied into the frame at the rising edge that starts bit 0. A write made during a frame, including one in the very clock of that edge, takes effect from the following frame. If no write is made, the previous word is sent again. The word held after reset is 0.
- R6: sdi is sampled on each falling sclk edge. The first sample of a frame becomes bit 31 of the received word and the last sample becomes bit 0.
- R7: rx_valid is high for exactly one system clock: the one in which sclk falls at the end of bit 31. rx_data takes the new word in that same clock and holds it unchanged at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_wr | input | 1 | Stores tx_x and tx_y as the next outbound pair |
| tx_x | input | 16 | X axis position, sent in word bits 31:16 |
| tx_y | input | 16 | Y axis position, sent in word bits 15:0 |
| sdi | input | 1 | Return data from the scanner head |
| sclk | output | 1 | Bit clock to the head |
| sync_n | output | 1 | Active-low frame strobe |
| sdo | output | 1 | Outbound serial data |
| rx_valid | output | 1 | One-cycle pulse when a reply word is complete |
| rx_data | output | 32 | Last complete reply word |

## Verification
A wrong bit counter shows within one frame. The sync low stretch would have the wrong length or position, or rx_valid would fire on some other falling edge. A slipped shift register or a wrong load moment scrambles or delays the word on sdo, and it is exposed by the first frame carrying a new value. A divider fault changes the sclk level lengths at once, and every output cycle is compared against an independent cycle model, so any of these faults is caught on the first cycle that differs.

// File: rtl/scan_link_pkg.sv
package scan_link_pkg;
  localparam int AXIS_W = 16;
  localparam int WORD_W = 2 * AXIS_W;
  localparam int IDX_W  = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [IDX_W-1:0]  idx_t;
endpackage

// File: rtl/sl_timing.sv
module sl_timing
  import scan_link_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic sclk,
  output logic rise_ev,
  output logic fall_ev,
  output idx_t cur_bit,
  output idx_t nxt_bit
);
  localparam int HCNT_W = $clog2(HALF_DIV + 1);
  localparam logic [HCNT_W-1:0] HCNT_TOP = HCNT_W'(HALF_DIV - 1);

  logic [HCNT_W-1:0] hcnt_q, hcnt_d;
  logic              sclk_q, sclk_d;
  idx_t              bit_q, bit_d;
  logic              tick;

  always_comb begin
    tick    = (hcnt_q == HCNT_TOP);
    rise_ev = tick & ~sclk_q;
    fall_ev = tick & sclk_q;
    hcnt_d  = tick ? '0 : hcnt_q + 1'b1;
    sclk_d  = tick ? ~sclk_q : sclk_q;
    nxt_bit = (bit_q == LAST_IDX) ? '0 : bit_q + 1'b1;
    bit_d   = rise_ev ? nxt_bit : bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      sclk_q <= 1'b0;
      bit_q  <= LAST_IDX;
    end else begin
      hcnt_q <= hcnt_d;
      if (tick)    sclk_q <= sclk_d;
      if (rise_ev) bit_q  <= bit_d;
    end
  end

  assign sclk    = sclk_q;
  assign cur_bit = bit_q;
endmodule

// File: rtl/sl_tx_path.sv
module sl_tx_path
  import scan_link_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [AXIS_W-1:0] x_in,
  input  logic [AXIS_W-1:0] y_in,
  input  logic              rise_ev,
  input  idx_t              nxt_bit,
  output logic              sdo,
  output logic              sync_n
);
  word_t             pend_q;
  logic [WORD_W-2:0] sh_q, sh_d;
  logic              sdo_q, sdo_d;
  logic              sync_q, sync_d;
  logic              start;

  always_comb begin
    start  = (nxt_bit == '0);
    sync_d = (nxt_bit != LAST_IDX);
    if (start) begin
      sdo_d = pend_q[WORD_W-1];
      sh_d  = pend_q[WORD_W-2:0];
    end else begin
      sdo_d = sh_q[WORD_W-2];
      sh_d  = {sh_q[WORD_W-3:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      sh_q   <= '0;
      sdo_q  <= 1'b0;
      sync_q <= 1'b1;
    end else begin
      if (wr) pend_q <= {x_in, y_in};
      if (rise_ev) begin
        sh_q   <= sh_d;
        sdo_q  <= sdo_d;
        sync_q <= ~sync_d;
      end
    end
  end

  assign sdo    = sdo_q;
  assign sync_n = sync_q;
endmodule

// File: rtl/sl_rx_path.sv
module sl_rx_path
  import scan_link_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sdi,
  input  logic  fall_ev,
  input  idx_t  cur_bit,
  output logic  valid,
  output word_t data
);
  logic [WORD_W-2:0] sh_q, sh_d;
  word_t             data_q, data_d;
  logic              valid_d, valid_q;
  logic              last;

  always_comb begin
    last    = (cur_bit == LAST_IDX);
    sh_d    = {sh_q[WORD_W-3:0], sdi};
    data_d  = {sh_q, sdi};
    valid_d = fall_ev & last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (fall_ev) sh_q   <= sh_d;
      if (valid_d) data_q <= data_d;
    end
  end

  assign valid = valid_q;
  assign data  = data_q;
endmodule

// File: rtl/scan_duplex_link.sv
module scan_duplex_link
  import scan_link_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_wr,
  input  logic [AXIS_W-1:0] tx_x,
  input  logic [AXIS_W-1:0] tx_y,
  input  logic              sdi,
  output logic              sclk,
  output logic              sync_n,
  output logic              sdo,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data
);
  logic [1:0] rsync_q;
  logic       rst_sync_n;
  logic       rise_ev, fall_ev;
  idx_t       cur_bit, nxt_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  sl_timing #(.HALF_DIV(HALF_DIV)) u_timing (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sclk    (sclk),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev),
    .cur_bit (cur_bit),
    .nxt_bit (nxt_bit)
  );

  sl_tx_path u_tx (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr      (tx_wr),
    .x_in    (tx_x),
    .y_in    (tx_y),
    .rise_ev (rise_ev),
    .nxt_bit (nxt_bit),
    .sdo     (sdo),
    .sync_n  (sync_n)
  );

  sl_rx_path u_rx (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sdi     (sdi),
    .fall_ev (fall_ev),
    .cur_bit (cur_bit),
    .valid   (rx_valid),
    .data    (rx_data)
  );
endmodule

// File: rtl/scan_duplex_link_chk.sv
module scan_duplex_link_chk #(
  parameter int HALF_DIV = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sclk,
  input logic        sync_n,
  input logic        sdo,
  input logic        rx_valid,
  input logic [31:0] rx_data
);
  localparam int RUN_W = $clog2(HALF_DIV + 2) + 1;

  logic             prev_sclk;
  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sclk <= 1'b0;
      run_len   <= '0;
    end else begin
      prev_sclk <= sclk;
      if (sclk != prev_sclk) run_len <= RUN_W'(1);
      else if (run_len != {RUN_W{1'b1}}) run_len <= run_len + 1'b1;
    end
  end

  AST_SCLK_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != prev_sclk) |-> (run_len == RUN_W'(HALF_DIV))); // R2

  AST_SYNC_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sync_n) |-> $rose(sclk)); // R3

  AST_SDO_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $rose(sclk)); // R4

  AST_RXV_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $fell(sclk)); // R7

  AST_RXV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R7

  AST_RXDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data)); // R7
endmodule

bind scan_duplex_link scan_duplex_link_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .sclk     (sclk),
  .sync_n   (sync_n),
  .sdo      (sdo),
  .rx_valid (rx_valid),
  .rx_data  (rx_data)
);

// File: tb/scan_duplex_link_bench.sv
`timescale 1ns/1ps
module scan_duplex_link_bench;
  localparam int H = 3;

  logic        clk;
  logic        rst_n;
  logic        tx_wr;
  logic [15:0] tx_x, tx_y;
  logic        sdi;
  logic        sclk, sync_n, sdo, rx_valid;
  logic [31:0] rx_data;

  int checks = 0;
  int fails  = 0;

  scan_duplex_link #(.HALF_DIV(H)) u_scan_duplex_link (
    .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_x(tx_x), .tx_y(tx_y),
    .sdi(sdi), .sclk(sclk), .sync_n(sync_n), .sdo(sdo),
    .rx_valid(rx_valid), .rx_data(rx_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] devw(input int f);
    return (32'h9E37_79B9 * (f + 1)) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int          rel, m_k, m_g;
  bit          m_sclk, m_sdo, m_sync_n, m_rv;
  logic [31:0] m_cur, m_pend, m_rsh, m_rdata;

  always @(posedge clk) begin
    int b;
    if (!rst_n || rel < 2) begin
      if (!rst_n) rel = 0; else rel++;
      m_k = 0; m_g = -1; m_sclk = 0; m_sdo = 0; m_sync_n = 1; m_rv = 0;
      m_cur = '0; m_pend = '0; m_rsh = '0; m_rdata = '0;
    end else begin
      m_rv = 0;
      m_k++;
      if (m_k % H == 0) begin
        m_sclk = !m_sclk;
        if (m_sclk) begin
          m_g++;
          b = m_g % 32;
          if (b == 0) m_cur = m_pend;
          m_sdo = m_cur[31-b];
          m_sync_n = (b == 31);
        end else begin
          b = m_g % 32;
          m_rsh = {m_rsh[30:0], sdi};
          if (b == 31) begin
            m_rdata = m_rsh;
            m_rv = 1;
          end
        end
      end
      if (tx_wr) m_pend = {tx_x, tx_y};
    end
  end

  // ---------------- compare, collect, drive sdi ----------------
  logic [31:0] expw [0:7];
  int          fstart_cnt = 0;
  int          fidx = 0;
  int          bitpos = 0;
  int          rx_frames = 0;
  logic [31:0] coll;
  logic        p_sclk = 1'b0, p_sync = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(sclk == m_sclk, "R2 sclk", {31'd0, sclk}, {31'd0, m_sclk});
      chk(sync_n == m_sync_n, "R3 sync_n", {31'd0, sync_n}, {31'd0, m_sync_n});
      chk(sdo == m_sdo, "R4/R5 sdo", {31'd0, sdo}, {31'd0, m_sdo});
      chk(rx_valid == m_rv, "R7 rx_valid", {31'd0, rx_valid}, {31'd0, m_rv});
      chk(rx_data == m_rdata, "R7 rx_data", rx_data, m_rdata);
      if (rx_valid) begin
        // R6: word assembled MSB first from what the head drove
        chk(rx_data == devw(m_g / 32), "R6 reply word", rx_data, devw(m_g / 32));
        rx_frames++;
      end
      if (sclk && !p_sclk) begin
        if (!sync_n && p_sync) begin
          bitpos = 0;
          coll = {31'd0, sdo};
          fstart_cnt++;
        end else begin
          bitpos++;
          coll = {coll[30:0], sdo};
        end
        if (bitpos == 31 && fidx < 8) begin
          // R4 field order, R5 latch timing and repetition
          chk(coll == expw[fidx], "R5 frame word", coll, expw[fidx]);
          fidx++;
        end
      end
      p_sclk = sclk;
      p_sync = sync_n;
    end
    if (m_g < 0) sdi <= 1'b0;
    else         sdi <= devw(m_g / 32)[31 - (m_g % 32)];
  end

  // ---------------- stimulus ----------------
  task automatic write_pair(input logic [15:0] x, input logic [15:0] y);
    tx_x  = x;
    tx_y  = y;
    tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  initial begin
    expw[0] = 32'h0000_0000;
    expw[1] = 32'h1234_ABCD;
    expw[2] = 32'h1234_ABCD;
    expw[3] = 32'h8001_7FFE;
    expw[4] = 32'hC0DE_0F0F;
    expw[5] = 32'hC0DE_0F0F;
    expw[6] = 32'hC0DE_0F0F;
    expw[7] = 32'hFACE_0001;
    rst_n = 1'b0; tx_wr = 1'b0; tx_x = '0; tx_y = '0;
    repeat (3) @(negedge clk);
    // R1: reset levels
    chk(sclk == 0 && sync_n == 1 && sdo == 0, "R1 line levels",
        {29'd0, sclk, sync_n, sdo}, 32'h2);
    chk(rx_valid == 0 && rx_data == 0, "R1 reply outputs", rx_data, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    wait (fstart_cnt == 1);
    repeat (20) @(negedge clk);
    write_pair(16'h1234, 16'hABCD);
    wait (fstart_cnt == 3);
    repeat (40) @(negedge clk);
    write_pair(16'h8001, 16'h7FFE);
    wait (fstart_cnt == 4);
    @(negedge clk);
    write_pair(16'h5555, 16'h2222);
    write_pair(16'hC0DE, 16'h0F0F);
    wait (fstart_cnt == 6);
    @(negedge clk);
    while (!(m_g % 32 == 31 && !m_sclk && ((m_k + 1) % H == 0))) @(negedge clk);
    // write lands on the edge that starts frame 7: it must wait one frame
    write_pair(16'hFACE, 16'h0001);
    wait (fidx == 8);
    @(negedge clk);
    chk(rx_frames >= 7, "R6 reply count", rx_frames, 7);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=8 frames", fidx);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule